// File: doc/BRIEF.md
# Parallel RGB Video to CSI-2 Lane Packetizer

This block takes a 24-bit RGB pixel stream, qualified by a vertical sync and a data-enable strobe, and produces CSI-2 packets spread over two or four byte-wide lanes. Each line is held in an internal buffer while it arrives. When the line ends, the block sends it as one long packet with a header, its ECC, the payload and a CRC footer. When vertical sync drops, a frame-end short packet and a frame-start short packet are queued, and both go out during vertical blanking.

For each lane the block presents a byte, a flag that marks a valid high-speed byte, and a two-bit low-power line code written as {P, N}. A downstream serializer and physical layer use these to drive the wires. Between packets every active lane returns to the stop state. The lane count is taken at the start of each packet.

Top module: `vcsi_packetizer`

## Requirements
- R1: After reset, and in every cycle with no burst in progress, every lane shows line code 2'b11, HS flag 0 and byte 8'h00.
- R2: A falling edge on `vsync` queues a frame-end short packet (data type 8'h01, data field = the 16-bit frame count). This is followed by a frame-start short packet (data type 8'h00, data field = count + 1). The count starts at 0 and is incremented by each frame start.
- R3: Each high period of `de` produces one long packet with data type 8'h24 and word count = 3 × captured pixels. The payload takes each pixel as bits [7:0], then [15:8], then [23:16]. Pixels beyond MAX_PIX in a line are dropped.
- R4: Every packet starts with four header bytes: data type, field low byte, field high byte, then an ECC byte. The ECC byte has bits 7:6 at zero and bits 5:0 holding the 6-bit Hamming parity of the 24-bit value {byte2, byte1, byte0}.
- R5: A long packet ends with a 16-bit CRC over the payload, low byte first. The CRC uses the reflected x^16+x^12+x^5+1 polynomial with seed 16'hFFFF and no final inversion.
- R6: Packet byte i goes on lane i mod N. N is 4 when `fourLane` is 1 and 2 when it is 0, taken at packet start. In two-lane mode lanes 2 and 3 stay at code 2'b11 with HS 0.
- R7: Each burst runs LP-01 (code 2'b01) for LPX_CYC cycles, then LP-00 (2'b00) for PREP_CYC cycles, then one cycle of sync byte 8'hB8 with HS set on every active lane. The packet bytes follow, then TRAIL_CYC cycles at code 2'b00 with HS 0, then 2'b11.
- R8: All active lanes carry the same line code in every cycle. In the final data cycle, lanes with no byte left show HS 0 and byte 0, and lane 0 always holds a byte.
- R9: Pending packets leave in the order frame-end, frame-start, then line. Every burst is separated from the next by at least one cycle at code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixData | input | 24 | RGB pixel |
| vsync | input | 1 | Vertical sync, active high |
| de | input | 1 | Data enable, high on active pixels |
| fourLane | input | 1 | 1 = four lanes, 0 = two lanes |
| laneByte | output | 32 | Lane k byte at bits [8k+7:8k] |
| laneHs | output | 4 | Per-lane valid high-speed byte flag |
| laneLp | output | 8 | Per-lane low-power code {P,N} at bits [2k+1:2k] |

## Verification
A stuck burst sequencer shows up within one burst as an LP-01, LP-00 or trail phase of the wrong length, or as a missing sync byte. A wrong byte index or a wrong latched lane count breaks the round-robin order, so the rebuilt packet differs from the model at its first misplaced byte. Errors in the capture counter or the CRC accumulator only appear when the line is sent, in the word count, ECC or footer of that packet. A lost queue flag shows up as a missing or reordered frame packet after the next vertical sync.

// File: rtl/vcsi_pkg.sv
package vcsi_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LP01, PH_LP00, PH_SYNC, PH_DATA, PH_TRAIL
  } phase_e;

  typedef enum logic [1:0] {
    PK_FEND, PK_FSTART, PK_LINE
  } pkt_e;

  typedef struct packed {
    phase_e phase;
    logic   load;
    pkt_e   kind;
    logic   advance;
  } ctlStrobe_t;

  localparam logic [7:0]  DT_FSTART  = 8'h00;
  localparam logic [7:0]  DT_FEND    = 8'h01;
  localparam logic [7:0]  DT_RGB24   = 8'h24;
  localparam logic [7:0]  SYNC_BYTE  = 8'hB8;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;

  // parity masks over the 24 header bits, entry 0 is parity bit 0
  localparam logic [5:0][23:0] ECC_MASK = {
    24'hEFFC00, 24'hDF03F0, 24'hB8E38E, 24'h749A6D, 24'hF2555B, 24'hF12CB7
  };

  function automatic logic [7:0] hdrEcc(input logic [23:0] h);
    logic [7:0] e;
    e = '0;
    for (int i = 0; i < 6; i++) e[i] = ^(h & ECC_MASK[i]);
    return e;
  endfunction

  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    return r;
  endfunction

endpackage

// File: rtl/vcsi_ctrl.sv
module vcsi_ctrl
  import vcsi_pkg::*;
#(
  parameter int LPX_CYC   = 2,
  parameter int PREP_CYC  = 3,
  parameter int TRAIL_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vsync,
  input  logic       lineReady,
  input  logic       lastBeat,
  output ctlStrobe_t ctl
);

  localparam int MAX_AB  = (LPX_CYC > PREP_CYC) ? LPX_CYC : PREP_CYC;
  localparam int CNT_MAX = (MAX_AB > TRAIL_CYC) ? MAX_AB : TRAIL_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);

  phase_e        state;
  logic [CW-1:0] cnt;
  logic          vsD;
  logic          pendFe;
  logic          pendFs;
  logic          vsFall;

  assign vsFall = vsD & ~vsync;

  always_comb begin
    ctl.phase   = state;
    ctl.load    = (state == PH_IDLE) && (pendFe || pendFs || lineReady);
    ctl.kind    = pendFe ? PK_FEND : (pendFs ? PK_FSTART : PK_LINE);
    ctl.advance = (state == PH_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= PH_IDLE;
      cnt    <= '0;
      vsD    <= 1'b0;
      pendFe <= 1'b0;
      pendFs <= 1'b0;
    end else begin
      vsD <= vsync;
      if (ctl.load && ctl.kind == PK_FEND)   pendFe <= 1'b0;
      if (ctl.load && ctl.kind == PK_FSTART) pendFs <= 1'b0;
      if (vsFall) begin
        pendFe <= 1'b1;
        pendFs <= 1'b1;
      end
      case (state)
        PH_IDLE: if (ctl.load) begin
          state <= PH_LP01;
          cnt   <= '0;
        end
        PH_LP01: if (cnt == CW'(LPX_CYC - 1)) begin
          state <= PH_LP00;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_LP00: if (cnt == CW'(PREP_CYC - 1)) begin
          state <= PH_SYNC;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        PH_SYNC: state <= PH_DATA;
        PH_DATA: if (lastBeat) begin
          state <= PH_TRAIL;
          cnt   <= '0;
        end
        PH_TRAIL: if (cnt == CW'(TRAIL_CYC - 1)) begin
          state <= PH_IDLE;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        default: state <= PH_IDLE;
      endcase
    end
  end

  AST_SYNC_TO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    state == PH_SYNC |=> state == PH_DATA); // R7
  AST_LP00_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    state == PH_LP00 |-> ($past(state) == PH_LP01 || $past(state) == PH_LP00)); // R7
  AST_VS_QUEUE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vsync) |=> (pendFe && pendFs)); // R2
  AST_FE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.kind == PK_FSTART) |-> !pendFe); // R9

endmodule

// File: rtl/vcsi_datapath.sv
module vcsi_datapath
  import vcsi_pkg::*;
#(
  parameter int MAX_PIX = 32,
  parameter int LANES   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [23:0]        pixData,
  input  logic               de,
  input  logic               fourLane,
  input  ctlStrobe_t         ctl,
  output logic               lineReady,
  output logic               lastBeat,
  output logic [LANES*8-1:0] laneByte,
  output logic [LANES-1:0]   laneHs,
  output logic [2*LANES-1:0] laneLp
);

  localparam int BUF_BYTES = 3 * MAX_PIX;
  localparam int PCW       = $clog2(MAX_PIX + 1);
  localparam int MW        = $clog2(BUF_BYTES);
  localparam int IW        = $clog2(BUF_BYTES + 6 + 2 * LANES + 1);
  localparam int LW        = $clog2(LANES + 1);

  logic [7:0]     lineMem [BUF_BYTES];
  logic           deD;
  logic [PCW-1:0] pixCnt, lineLen, wrPix;
  logic [15:0]    crcAcc, lineCrc, pktCrc, crcIn, crcNext;
  logic [23:0]    pktHdr;
  logic [IW-1:0]  pktWc, pktTotal, base;
  logic [LW-1:0]  nLanes;
  logic [15:0]    frameNum;
  logic           deRise, capture;

  assign deRise  = de & ~deD;
  assign capture = deRise | (de && (pixCnt < PCW'(MAX_PIX)));
  assign wrPix   = deRise ? '0 : pixCnt;
  assign crcIn   = deRise ? CRC_SEED : crcAcc;
  assign crcNext = crcByte(crcByte(crcByte(crcIn, pixData[7:0]), pixData[15:8]), pixData[23:16]);

  always_ff @(posedge clk) begin
    if (capture)
      for (int b = 0; b < 3; b++) lineMem[MW'(3 * int'(wrPix) + b)] <= pixData[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      deD       <= 1'b0;
      pixCnt    <= '0;
      lineLen   <= '0;
      crcAcc    <= CRC_SEED;
      lineCrc   <= CRC_SEED;
      pktCrc    <= CRC_SEED;
      lineReady <= 1'b0;
      pktHdr    <= '0;
      pktWc     <= '0;
      pktTotal  <= '0;
      base      <= '0;
      nLanes    <= '0;
      frameNum  <= '0;
    end else begin
      deD <= de;
      if (capture) begin
        pixCnt <= wrPix + PCW'(1);
        crcAcc <= crcNext;
      end
      if (ctl.load && ctl.kind == PK_LINE) lineReady <= 1'b0;
      if (!de && deD) begin
        lineReady <= 1'b1;
        lineLen   <= pixCnt;
        lineCrc   <= crcAcc;
      end
      if (ctl.load) begin
        base   <= '0;
        nLanes <= fourLane ? LW'(LANES) : LW'(LANES / 2);
        case (ctl.kind)
          PK_FEND: begin
            pktHdr   <= {frameNum, DT_FEND};
            pktWc    <= '0;
            pktTotal <= IW'(4);
          end
          PK_FSTART: begin
            frameNum <= frameNum + 16'd1;
            pktHdr   <= {frameNum + 16'd1, DT_FSTART};
            pktWc    <= '0;
            pktTotal <= IW'(4);
          end
          default: begin
            pktHdr   <= {16'(3 * int'(lineLen)), DT_RGB24};
            pktWc    <= IW'(3 * int'(lineLen));
            pktTotal <= IW'(3 * int'(lineLen) + 6);
            pktCrc   <= lineCrc;
          end
        endcase
      end else if (ctl.advance) begin
        base <= base + IW'(nLanes);
      end
    end
  end

  assign lastBeat = (base + IW'(nLanes)) >= pktTotal;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IW-1:0] idx;
    logic          avail;
    logic          active;
    logic [7:0]    pb;
    logic [7:0]    outB;
    logic          outH;
    logic [1:0]    outL;

    assign idx    = base + IW'(k);
    assign avail  = idx < pktTotal;
    assign active = LW'(k) < nLanes;

    always_comb begin
      if (idx < IW'(4)) begin
        case (idx[1:0])
          2'd0:    pb = pktHdr[7:0];
          2'd1:    pb = pktHdr[15:8];
          2'd2:    pb = pktHdr[23:16];
          default: pb = hdrEcc(pktHdr);
        endcase
      end else if (idx < pktWc + IW'(4)) begin
        pb = lineMem[MW'(idx - IW'(4))];
      end else if (idx == pktWc + IW'(4)) begin
        pb = pktCrc[7:0];
      end else begin
        pb = pktCrc[15:8];
      end
    end

    always_comb begin
      outB = 8'h00;
      outH = 1'b0;
      outL = 2'b11;
      if (active) begin
        case (ctl.phase)
          PH_LP01:  outL = 2'b01;
          PH_LP00:  outL = 2'b00;
          PH_SYNC: begin
            outL = 2'b00;
            outH = 1'b1;
            outB = SYNC_BYTE;
          end
          PH_DATA: begin
            outL = 2'b00;
            if (avail) begin
              outH = 1'b1;
              outB = pb;
            end
          end
          PH_TRAIL: outL = 2'b00;
          default:  outL = 2'b11;
        endcase
      end
    end

    assign laneByte[8*k +: 8] = outB;
    assign laneHs[k]          = outH;
    assign laneLp[2*k +: 2]   = outL;
  end

  AST_IDLE_STOP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.phase == PH_IDLE |-> ((&laneLp) && laneHs == '0)); // R1
  AST_LANE0_DATA: assert property (@(posedge clk) disable iff (!rstN)
    ctl.phase == PH_DATA |-> laneHs[0]); // R8
  AST_HS_PACKED: assert property (@(posedge clk) disable iff (!rstN)
    (laneHs & (laneHs + 1'b1)) == '0); // R8
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.kind == PK_FSTART) |=> frameNum == $past(frameNum) + 16'd1); // R2
  AST_HALF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (nLanes == LW'(LANES / 2)) |-> (&laneLp[2*LANES-1:LANES])); // R6

endmodule

// File: rtl/vcsi_packetizer.sv
module vcsi_packetizer
  import vcsi_pkg::*;
#(
  parameter int MAX_PIX   = 32,
  parameter int LANES     = 4,
  parameter int LPX_CYC   = 2,
  parameter int PREP_CYC  = 3,
  parameter int TRAIL_CYC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [23:0]        pixData,
  input  logic               vsync,
  input  logic               de,
  input  logic               fourLane,
  output logic [LANES*8-1:0] laneByte,
  output logic [LANES-1:0]   laneHs,
  output logic [2*LANES-1:0] laneLp
);

  ctlStrobe_t ctl;
  logic       lineReady;
  logic       lastBeat;

  vcsi_ctrl #(
    .LPX_CYC(LPX_CYC), .PREP_CYC(PREP_CYC), .TRAIL_CYC(TRAIL_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .vsync(vsync),
    .lineReady(lineReady), .lastBeat(lastBeat), .ctl(ctl)
  );

  vcsi_datapath #(
    .MAX_PIX(MAX_PIX), .LANES(LANES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pixData(pixData), .de(de), .fourLane(fourLane),
    .ctl(ctl), .lineReady(lineReady), .lastBeat(lastBeat),
    .laneByte(laneByte), .laneHs(laneHs), .laneLp(laneLp)
  );

endmodule

// File: tb/vcsi_packetizer_tb.sv
module vcsi_packetizer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_PIX    = 32;
  localparam int LANES      = 4;
  localparam int LPX        = 2;
  localparam int PREP       = 3;
  localparam int TRAIL      = 2;
  localparam int WD_CYCLES  = 60000;

  // {pixels[15:8], seed[7:1], fourLane[0]}
  localparam logic [15:0] VEC [7] = '{
    {8'd1,  7'd3,   1'b1},
    {8'd1,  7'd5,   1'b0},
    {8'd5,  7'd17,  1'b1},
    {8'd6,  7'd40,  1'b0},
    {8'd32, 7'd77,  1'b1},
    {8'd40, 7'd9,   1'b0},
    {8'd11, 7'd100, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [23:0] pixData;
  logic        vsync, de, fourLane;
  logic [31:0] laneByte;
  logic [3:0]  laneHs;
  logic [7:0]  laneLp;

  vcsi_packetizer #(
    .MAX_PIX(MAX_PIX), .LANES(LANES), .LPX_CYC(LPX), .PREP_CYC(PREP), .TRAIL_CYC(TRAIL)
  ) u_dut (
    .clk(clk), .rstN(rstN), .pixData(pixData), .vsync(vsync), .de(de),
    .fourLane(fourLane), .laneByte(laneByte), .laneHs(laneHs), .laneLp(laneLp)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] eccRef(input logic [23:0] h);
    logic [23:0] m [6];
    logic [7:0] e;
    m[0] = 24'hF12CB7; m[1] = 24'hF2555B; m[2] = 24'h749A6D;
    m[3] = 24'hB8E38E; m[4] = 24'hDF03F0; m[5] = 24'hEFFC00;
    e = 8'h00;
    for (int i = 0; i < 6; i++) e[i] = ^(h & m[i]);
    return e;
  endfunction

  function automatic logic [15:0] crcRef(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
      else r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [23:0] pixVal(input int s, input int i);
    return {8'(s * 5 + i * 3), 8'(i * 29 + 7), 8'(s ^ (i * 11))};
  endfunction

  // expected packet store
  logic [7:0] expMem [4096];
  int expOff [128];
  int expLen [128];
  int expCnt   = 0;
  int expFill  = 0;
  int frameCnt = 0;
  int expLanes = 4;

  task automatic pushByte(input logic [7:0] b);
    expMem[expFill] = b;
    expFill++;
  endtask

  task automatic addShort(input logic [7:0] dt, input logic [15:0] fld);
    expOff[expCnt] = expFill;
    pushByte(dt); pushByte(fld[7:0]); pushByte(fld[15:8]);
    pushByte(eccRef({fld, dt}));
    expLen[expCnt] = 4;
    expCnt++;
  endtask

  task automatic addLong(input int n, input int seed);
    int m;
    logic [15:0] wc, crc;
    logic [23:0] p;
    m = (n > MAX_PIX) ? MAX_PIX : n;
    wc = 16'(3 * m);
    expOff[expCnt] = expFill;
    pushByte(8'h24); pushByte(wc[7:0]); pushByte(wc[15:8]);
    pushByte(eccRef({wc, 8'h24}));
    crc = 16'hFFFF;
    for (int i = 0; i < m; i++) begin
      p = pixVal(seed, i);
      for (int b = 0; b < 3; b++) begin
        pushByte(p[8*b +: 8]);
        crc = crcRef(crc, p[8*b +: 8]);
      end
    end
    pushByte(crc[7:0]); pushByte(crc[15:8]);
    expLen[expCnt] = 4 + 3 * m + 2;
    expCnt++;
  endtask

  // lane monitor, samples at the falling edge
  logic [7:0] got [512];
  int gotN = 0;
  int mState = 0;
  int runCnt = 0;
  int pktSeen = 0;
  bit alignErr = 0;
  bit contigErr = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (mState != 0) begin
        for (int k = 0; k < LANES; k++) begin
          if (k < expLanes) begin
            if (laneLp[2*k +: 2] != laneLp[1:0]) alignErr = 1;
          end else if (laneLp[2*k +: 2] != 2'b11 || laneHs[k]) begin
            alignErr = 1;
          end
        end
      end
      case (mState)
        0: if (laneLp[1:0] == 2'b01) begin
          mState = 1; runCnt = 1; gotN = 0; alignErr = 0; contigErr = 0;
        end
        1: if (laneLp[1:0] == 2'b01) runCnt++;
          else begin
            chk(laneLp[1:0] == 2'b00 && runCnt == LPX, "R7 LP-01 length", runCnt, LPX);
            runCnt = 1; mState = 2;
          end
        2: if (!laneHs[0]) runCnt++;
          else begin
            bit syncOk;
            chk(runCnt == PREP, "R7 LP-00 length", runCnt, PREP);
            syncOk = 1;
            for (int k = 0; k < expLanes; k++)
              if (!laneHs[k] || laneByte[8*k +: 8] != 8'hB8) syncOk = 0;
            chk(syncOk, "R7 sync byte on active lanes", laneByte, 32'hB8B8B8B8);
            mState = 3;
          end
        3: if (laneHs[0]) begin
            bit gap;
            gap = 0;
            for (int k = 0; k < expLanes; k++) begin
              if (laneHs[k]) begin
                if (gap) contigErr = 1;
                got[gotN] = laneByte[8*k +: 8];
                gotN++;
              end else begin
                gap = 1;
                if (laneByte[8*k +: 8] != 8'h00) contigErr = 1;
              end
            end
          end else begin
            runCnt = 1; mState = 4;
          end
        default: if (laneLp[1:0] == 2'b11) begin
            chk(runCnt == TRAIL, "R7 trail length", runCnt, TRAIL);
            chk(!alignErr, "R6 R8 lane code alignment", alignErr, 0);
            chk(!contigErr, "R8 final beat padding", contigErr, 0);
            if (pktSeen >= expCnt) begin
              chk(0, "R9 unexpected packet", pktSeen, expCnt);
            end else begin
              int bad;
              bad = -1;
              chk(gotN == expLen[pktSeen], $sformatf("R3 packet %0d length", pktSeen),
                  gotN, expLen[pktSeen]);
              for (int i = 0; i < gotN && i < expLen[pktSeen]; i++)
                if (bad < 0 && got[i] != expMem[expOff[pktSeen] + i]) bad = i;
              if (bad < 0) chk(1, "R2 R4 R5 R9 content", 0, 0);
              else chk(0, $sformatf("R2 R4 R5 R6 R9 packet %0d byte %0d", pktSeen, bad),
                       got[bad], expMem[expOff[pktSeen] + bad]);
            end
            pktSeen++;
            mState = 0;
          end else runCnt++;
      endcase
    end
  end

  task automatic frameSync();
    addShort(8'h01, 16'(frameCnt));
    frameCnt++;
    addShort(8'h00, 16'(frameCnt));
    @(negedge clk) vsync = 1'b1;
    repeat (3) @(negedge clk);
    vsync = 1'b0;
  endtask

  task automatic sendLine(input int n, input int seed);
    addLong(n, seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      de = 1'b1;
      pixData = pixVal(seed, i);
    end
    @(negedge clk);
    de = 1'b0;
    pixData = '0;
  endtask

  task automatic drain();
    while (pktSeen < expCnt) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic idleCheck(input string tag);
    chk(laneLp == 8'hFF && laneHs == 4'h0 && laneByte == 32'h0, tag,
        {laneByte[23:0], laneLp}, 32'h0000_00FF);
  endtask

  initial begin
    rstN = 1'b0; vsync = 1'b0; de = 1'b0; pixData = '0; fourLane = 1'b1;
    repeat (3) @(negedge clk);
    idleCheck("R1 lanes during reset");
    rstN = 1'b1;
    @(negedge clk);
    idleCheck("R1 lanes after reset");

    // table walk: frame sync pair then one line per vector
    for (int v = 0; v < 7; v++) begin
      fourLane = VEC[v][0];
      expLanes = VEC[v][0] ? 4 : 2;
      frameSync();
      drain();
      sendLine(int'(VEC[v][15:8]), int'(VEC[v][7:1]));
      drain();
      idleCheck("R1 stop state between packets");
    end

    // R9: line captured while the frame pair is still being sent
    fourLane = 1'b0; expLanes = 2;
    frameSync();
    sendLine(3, 9);
    drain();

    // R3 truncation at the buffer limit on four lanes, R6 mode switch
    fourLane = 1'b1; expLanes = 4;
    sendLine(MAX_PIX + 5, 55);
    drain();

    // R8: two-pixel line leaves a partial last beat on four lanes
    sendLine(2, 21);
    drain();

    chk(pktSeen == expCnt, "R9 packet count", pktSeen, expCnt);
    idleCheck("R1 final stop state");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9 packet flow stalled actual=0x%0h expected=0x%0h", pktSeen, expCnt);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule